// File: doc/BRIEF.md
# Auto-Baud Register Access Slave

This block is the slave end of a UART-style control channel with one receive line and one transmit line. It has no fixed bit rate. Every packet opens with a known timing byte, 0x79. The slave counts system clocks across that byte to learn the host's bit period, and then frames the rest of the packet at that rate. Between packets the host may change its rate by up to 3.5 times in either direction, and the slave follows.

A packet that passes all checks is answered with the byte 0xC3, sent at the learned rate. Write data is held in a staging buffer while this answer goes out. It is copied into the register file only once the answer's stop bit has left the line, so a write that changes link settings cannot damage its own answer. A read packet is answered with 0xC3 followed by the requested register bytes. A packet that fails any check gets no answer, and the host treats a missing answer as a failed transaction after its own timeout.

Top module: `autobaud_reg_slave`

## Requirements
- R1: While reset is asserted and after it is released, tx_o is high and every register reads 0x00 on rd_data_o.
- R2: The slave measures the bit period from the three falling edges of the timing byte 0x79, which span 8 bit times. It re-learns the period on every packet, including packets whose rate is 3.5 times above or below the rate of the packet before.
- R3: On both lines a character is 1 start bit (0), 8 data bits with the least significant bit first, 1 even-parity bit and 1 stop bit (1). The slave samples each received bit at mid-bit.
- R4: Once 16 learned bit times of high line follow a character, the framing resets and the next falling edge starts a new period measurement. A shorter high gap continues the current packet.
- R5: The byte after the timing byte holds the device address in bits [7:1] and the direction in bit 0, where 1 means read. If the address differs from DEV_ADDR, the slave sends nothing and changes no register.
- R6: A write packet is: timing byte, address byte, register address, byte count N, then N data bytes. If it is accepted, the slave answers with 0xC3.
- R7: Registers written by a write packet keep their old value until the stop bit of the 0xC3 answer has been fully sent. They hold the new value within a few clocks after that.
- R8: A read packet is: timing byte, address byte, register address, count N. The slave answers with 0xC3 and then N bytes taken from consecutive registers. Register addresses wrap modulo REG_DEPTH, for reads and writes alike.
- R9: A parity error or a stop-bit error in any received character, or a count of 0 or a count above MAX_BURST, aborts the packet. No answer is sent and no register changes.
- R10: The start bit of the answer begins between 1 and 1.5 bit times after the end of the host's last stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line from the host, idles high |
| tx_o | output | 1 | Serial line to the host, idles high |
| rd_addr_i | input | 4 | Register file read address |
| rd_data_o | output | 8 | Register file read data |

## Verification
The bench moves the host rate from 50 clocks per bit up to 175 and back down, so a slave that keeps a stale period would misframe the read answer. It samples the register file partway through the stop bit of the 0xC3 answer and again just after the answer ends: a design that commits early shows the new value at the first sample, and a design that never commits shows the old value at the second. Burst accesses that straddle the top of the register file would expose missing wrap-around. Two further cases target the framing rules. A gap of 8 bit times inside a packet must not break it, and a gap of 20 bit times after a half-sent packet must resynchronise; a slave that ignored the boundary would take the new timing byte as a register address. Bad parity, a bad stop bit, a foreign address and out-of-range counts must each leave the line silent and the registers unchanged.

// File: rtl/abr_pkg.sv
package abr_pkg;
  localparam logic [7:0] SYNC_BYTE = 8'h79;
  localparam logic [7:0] ACK_BYTE  = 8'hC3;

  typedef enum logic [1:0] {RX_HUNT, RX_MEAS, RX_BITS, RX_WAIT} rx_state_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_REG, ST_CNT, ST_WDAT, ST_TURN, ST_ACK, ST_RDAT
  } ctl_state_e;
endpackage

// File: rtl/abr_rx.sv
module abr_rx import abr_pkg::*; #(
  parameter int MAX_BIT_CLKS = 8192,
  localparam int PW = $clog2(MAX_BIT_CLKS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  output logic [PW-1:0] period_o,
  output logic          sync_o,
  output logic          chr_vld_o,
  output logic          chr_err_o,
  output logic [7:0]    chr_o,
  output logic          gap_o
);
  localparam int MW = PW + 3;
  localparam int GW = PW + 4;

  rx_state_e     st_q;
  logic [2:0]    s_q;
  logic [MW-1:0] mcnt_q;
  logic          nfall_q, in_sync_q;
  logic [PW-1:0] ph_q;
  logic [3:0]    nleft_q;
  logic [10:0]   sh_q;
  logic [GW-1:0] gcnt_q;

  logic          line, fall;
  logic [10:0]   nsh;
  logic [MW-1:0] mrnd;

  assign line = s_q[1];
  assign fall = s_q[2] & ~s_q[1];
  assign nsh  = {line, sh_q[10:1]};
  assign mrnd = mcnt_q + MW'(4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= RX_HUNT; s_q <= 3'b111; mcnt_q <= '0; nfall_q <= 1'b0;
      in_sync_q <= 1'b0; ph_q <= '0; nleft_q <= '0; sh_q <= '1; gcnt_q <= '0;
      period_o <= '0; sync_o <= 1'b0; chr_vld_o <= 1'b0; chr_err_o <= 1'b0;
      chr_o <= '0; gap_o <= 1'b0;
    end else begin
      s_q <= {s_q[1:0], rx_i};
      sync_o <= 1'b0; chr_vld_o <= 1'b0; chr_err_o <= 1'b0; gap_o <= 1'b0;
      unique case (st_q)
        RX_HUNT: if (fall) begin
          st_q <= RX_MEAS; mcnt_q <= MW'(1); nfall_q <= 1'b0;
        end
        RX_MEAS: begin
          mcnt_q <= mcnt_q + 1'b1;
          if (&mcnt_q) st_q <= RX_HUNT;
          else if (fall) begin
            if (!nfall_q) nfall_q <= 1'b1;
            else if (mcnt_q < MW'(16)) st_q <= RX_HUNT;
            else begin
              // third fall opens bit 7 of the timing byte: 8 bit times measured
              period_o  <= PW'(mrnd >> 3);
              ph_q      <= PW'((mcnt_q + MW'(8)) >> 4);
              nleft_q   <= 4'd3;
              in_sync_q <= 1'b1;
              st_q      <= RX_BITS;
            end
          end
        end
        RX_BITS: begin
          if (ph_q == '0) begin
            sh_q    <= nsh;
            ph_q    <= period_o - 1'b1;
            nleft_q <= nleft_q - 1'b1;
            if (nleft_q == 4'd1) begin
              st_q <= RX_WAIT; gcnt_q <= '0; chr_o <= nsh[8:1];
              if (in_sync_q) begin
                in_sync_q <= 1'b0;
                sync_o    <= ~nsh[8] & nsh[9] & nsh[10];
              end else if (~nsh[0] & nsh[10] & ~(^nsh[9:1])) chr_vld_o <= 1'b1;
              else chr_err_o <= 1'b1;
            end
          end else ph_q <= ph_q - 1'b1;
        end
        RX_WAIT: begin
          if (fall) begin
            st_q <= RX_BITS; ph_q <= period_o >> 1; nleft_q <= 4'd11;
          end else if (line) begin
            gcnt_q <= gcnt_q + 1'b1;
            if (gcnt_q >= {period_o, 4'b0}) begin
              gap_o <= 1'b1; st_q <= RX_HUNT;
            end
          end else gcnt_q <= '0;
        end
        default: st_q <= RX_HUNT;
      endcase
    end
  end

  // R4
  gap_on_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_o |-> $past(line));
endmodule

// File: rtl/abr_tx.sv
module abr_tx #(
  parameter int PW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    byte_i,
  input  logic [PW-1:0] period_i,
  output logic          tx_o,
  output logic          busy_o,
  output logic          done_o
);
  logic [9:0]    sh_q;
  logic [3:0]    nb_q;
  logic [PW-1:0] cnt_q, per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_o <= 1'b1; busy_o <= 1'b0; done_o <= 1'b0;
      sh_q <= '1; nb_q <= '0; cnt_q <= '0; per_q <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          tx_o <= 1'b0; busy_o <= 1'b1;
          sh_q <= {1'b1, ^byte_i, byte_i};
          nb_q <= 4'd10; per_q <= period_i; cnt_q <= period_i - 1'b1;
        end
      end else if (cnt_q == '0) begin
        if (nb_q == '0) begin
          busy_o <= 1'b0; done_o <= 1'b1;
        end else begin
          tx_o  <= sh_q[0];
          sh_q  <= sh_q >> 1;
          nb_q  <= nb_q - 1'b1;
          cnt_q <= per_q - 1'b1;
        end
      end else cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3
  stop_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> tx_o);
endmodule

// File: rtl/autobaud_reg_slave.sv
module autobaud_reg_slave import abr_pkg::*; #(
  parameter logic [6:0] DEV_ADDR     = 7'h2A,
  parameter int         REG_DEPTH    = 16,
  parameter int         MAX_BURST    = 4,
  parameter int         MAX_BIT_CLKS = 8192,
  localparam int        AW = $clog2(REG_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  output logic          tx_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  localparam int PW = $clog2(MAX_BIT_CLKS + 1);
  localparam int BW = $clog2(MAX_BURST + 1);
  localparam int IW = $clog2(MAX_BURST);
  localparam logic [7:0] MAXB8 = 8'(MAX_BURST);

  logic [PW-1:0] period;
  logic          sync, chr_vld, chr_err, gap;
  logic [7:0]    chr;
  logic          tx_start, tx_busy, tx_done, tx_line;
  logic [7:0]    tx_byte;

  ctl_state_e    st_q;
  logic          rd_q;
  logic [7:0]    base_q;
  logic [BW-1:0] cnt_q, idx_q;
  logic [PW:0]   tmr_q;
  logic [7:0]    stage_q [MAX_BURST];
  logic [7:0]    regs_q  [REG_DEPTH];
  logic          rcv, wr_commit;
  logic [PW:0]   turn_len;

  function automatic logic [AW-1:0] slot(input logic [7:0] b, input logic [BW-1:0] k);
    return AW'(b + 8'(k));
  endfunction

  abr_rx #(.MAX_BIT_CLKS(MAX_BIT_CLKS)) u_rx (
    .clk_i, .rst_ni, .rx_i, .period_o(period), .sync_o(sync),
    .chr_vld_o(chr_vld), .chr_err_o(chr_err), .chr_o(chr), .gap_o(gap));

  abr_tx #(.PW(PW)) u_tx (
    .clk_i, .rst_ni, .start_i(tx_start), .byte_i(tx_byte), .period_i(period),
    .tx_o(tx_line), .busy_o(tx_busy), .done_o(tx_done));

  assign tx_o      = tx_line;
  assign rd_data_o = regs_q[rd_addr_i];
  assign rcv       = st_q inside {ST_IDLE, ST_DEV, ST_REG, ST_CNT, ST_WDAT};
  assign wr_commit = (st_q == ST_ACK) && tx_done && !rd_q;
  // turnaround: half the stop bit still to run, plus one full bit
  assign turn_len  = {1'b0, period} + (PW+1)'(period >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; rd_q <= 1'b0; base_q <= '0; cnt_q <= '0; idx_q <= '0;
      tmr_q <= '0; tx_start <= 1'b0; tx_byte <= '0;
      for (int i = 0; i < MAX_BURST; i++) stage_q[i] <= '0;
    end else begin
      tx_start <= 1'b0;
      if (rcv && (gap || chr_err)) st_q <= ST_IDLE;
      else if (rcv && sync) st_q <= ST_DEV;
      else unique case (st_q)
        ST_DEV: if (chr_vld) begin
          if (chr[7:1] == DEV_ADDR) begin rd_q <= chr[0]; st_q <= ST_REG; end
          else st_q <= ST_IDLE;
        end
        ST_REG: if (chr_vld) begin base_q <= chr; st_q <= ST_CNT; end
        ST_CNT: if (chr_vld) begin
          if (chr == 8'd0 || chr > MAXB8) st_q <= ST_IDLE;
          else begin
            cnt_q <= BW'(chr); idx_q <= '0;
            if (rd_q) begin st_q <= ST_TURN; tmr_q <= turn_len; end
            else st_q <= ST_WDAT;
          end
        end
        ST_WDAT: if (chr_vld) begin
          stage_q[IW'(idx_q)] <= chr;
          idx_q <= idx_q + 1'b1;
          if (idx_q == cnt_q - 1'b1) begin st_q <= ST_TURN; tmr_q <= turn_len; end
        end
        ST_TURN: if (tmr_q == '0) begin
          tx_start <= 1'b1; tx_byte <= ACK_BYTE; st_q <= ST_ACK;
        end else tmr_q <= tmr_q - 1'b1;
        ST_ACK: if (tx_done) begin
          if (rd_q) begin
            tx_start <= 1'b1; tx_byte <= regs_q[slot(base_q, '0)];
            idx_q <= '0; st_q <= ST_RDAT;
          end else st_q <= ST_IDLE;
        end
        ST_RDAT: if (tx_done) begin
          if (idx_q == cnt_q - 1'b1) st_q <= ST_IDLE;
          else begin
            idx_q <= idx_q + 1'b1; tx_start <= 1'b1;
            tx_byte <= regs_q[slot(base_q, idx_q + 1'b1)];
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // deferred commit of the staged burst
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < REG_DEPTH; i++) regs_q[i] <= '0;
    end else if (wr_commit) begin
      for (int i = 0; i < MAX_BURST; i++)
        if (BW'(i) < cnt_q) regs_q[slot(base_q, BW'(i))] <= stage_q[i];
    end
  end

  // R7
  commit_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit |-> tx_line && !tx_busy);
  // R5
  quiet_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !tx_busy) |-> tx_line);
  // R10
  start_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start |-> !tx_busy);
endmodule

// File: tb/autobaud_reg_slave_test.sv
module autobaud_reg_slave_test;
  localparam int TMO = 50000;  // 1 ms at 50 MHz

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       rx = 1'b1;
  logic [3:0] rd_addr = '0;
  logic       tx;
  logic [7:0] rd_data;

  int n_chk = 0, n_bad = 0, cyc = 0, P = 50, tx_falls = 0, fall_cyc = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  autobaud_reg_slave uut (.clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tx_o(tx),
                          .rd_addr_i(rd_addr), .rd_data_o(rd_data));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // monitor: decode every character on tx and score it
  initial begin
    logic [7:0] d, e;
    logic s0, pb, sb;
    string r;
    forever begin
      @(negedge tx);
      tx_falls++; fall_cyc = cyc;
      repeat (P/2) @(negedge clk);
      s0 = tx;
      for (int i = 0; i < 8; i++) begin repeat (P) @(negedge clk); d[i] = tx; end
      repeat (P) @(negedge clk); pb = tx;
      repeat (P) @(negedge clk); sb = tx;
      chk(!s0 && sb && (pb == ^d), "R3 tx framing", {s0, pb, sb}, {1'b0, ^d, 1'b1});
      if (exp_q.size() == 0) chk(0, "R5 unexpected tx byte", d, 0);
      else begin
        e = exp_q.pop_front(); r = req_q.pop_front();
        chk(d == e, r, d, e);
      end
    end
  end

  task automatic expect_byte(input logic [7:0] b, input string r);
    exp_q.push_back(b); req_q.push_back(r);
  endtask

  task automatic bit_out(input logic v);
    rx <= v;
    repeat (P) @(negedge clk);
  endtask

  task automatic char_out(input logic [7:0] d, input bit bad_par = 0, input bit bad_stop = 0);
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) bit_out(d[i]);
    bit_out((^d) ^ bad_par);
    bit_out(~bad_stop);
    rx <= 1'b1;
  endtask

  task automatic idle_bits(input int n);
    rx <= 1'b1;
    repeat (n * P) @(negedge clk);
  endtask

  task automatic set_rate(input int np);
    int m;
    m = (np > P) ? np : P;
    rx <= 1'b1;
    repeat (18 * m) @(negedge clk);
    P = np;
  endtask

  task automatic hdr(input logic [6:0] dev, input logic rw, input logic [7:0] ra, input logic [7:0] n);
    char_out(8'h79); char_out({dev, rw}); char_out(ra); char_out(n);
  endtask

  task automatic await_resp(input string r);
    int t_end, f0, k, d;
    t_end = cyc; f0 = tx_falls; k = 0;
    while (tx_falls == f0 && k < TMO) begin @(negedge clk); k++; end
    if (k >= TMO) begin
      chk(0, {r, " answer timeout"}, 0, 8'hC3);
      exp_q.delete(); req_q.delete();
    end else begin
      d = fall_cyc - t_end;
      chk(d >= P && d <= P + P/2, "R10 turnaround", d, P);
      k = 0;
      while (exp_q.size() != 0 && k < TMO) begin @(negedge clk); k++; end
      if (k >= TMO) begin
        chk(0, {r, " answer incomplete"}, exp_q.size(), 0);
        exp_q.delete(); req_q.delete();
      end
    end
    repeat (P) @(negedge clk);
  endtask

  task automatic expect_quiet(input string r, input int nbits);
    int f0;
    f0 = tx_falls;
    repeat (nbits * P) @(negedge clk);
    chk(tx_falls == f0 && tx == 1'b1, r, tx_falls - f0, 0);
  endtask

  task automatic read_reg(input logic [3:0] a, input logic [7:0] e, input string r);
    rd_addr <= a;
    @(negedge clk);
    chk(rd_data == e, r, rd_data, e);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(tx == 1'b1, "R1 tx idle in reset", tx, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx == 1'b1, "R1 tx idle after reset", tx, 1);
    read_reg(4'd3, 8'h00, "R1 reg3 reset");
    read_reg(4'd14, 8'h00, "R1 reg14 reset");
    idle_bits(4);

    // R2 R6 R7: single write at 50 clocks/bit with deferred commit
    rd_addr <= 4'd3;
    hdr(7'h2A, 1'b0, 8'h03, 8'd1); char_out(8'hA5);
    expect_byte(8'hC3, "R6 write ack");
    fork
      await_resp("R6");
      begin
        @(negedge tx);
        repeat (10 * P + P/2) @(negedge clk);
        chk(rd_data == 8'h00, "R7 reg held during ack", rd_data, 8'h00);
        repeat (P/2 + 6) @(negedge clk);
        chk(rd_data == 8'hA5, "R7 reg after ack", rd_data, 8'hA5);
      end
    join

    // R2 R8: read at 3.5x slower rate
    set_rate(175);
    hdr(7'h2A, 1'b1, 8'h03, 8'd1);
    expect_byte(8'hC3, "R2 slow relock ack"); expect_byte(8'hA5, "R8 read data");
    await_resp("R2");

    // R2 R6 R8: burst write wrapping past the top, back at 3.5x faster
    set_rate(50);
    hdr(7'h2A, 1'b0, 8'h0E, 8'd3);
    char_out(8'h11); char_out(8'h22); char_out(8'h33);
    expect_byte(8'hC3, "R2 fast relock ack");
    await_resp("R6");
    read_reg(4'd14, 8'h11, "R8 wrap write slot14");
    read_reg(4'd15, 8'h22, "R8 wrap write slot15");
    read_reg(4'd0,  8'h33, "R8 wrap write slot0");

    // R8: burst read with wrap
    set_rate(64);
    hdr(7'h2A, 1'b1, 8'h0E, 8'd3);
    expect_byte(8'hC3, "R8 read ack"); expect_byte(8'h11, "R8 burst b0");
    expect_byte(8'h22, "R8 burst b1"); expect_byte(8'h33, "R8 burst b2");
    await_resp("R8");

    // R5: foreign device address
    set_rate(64);
    hdr(7'h2B, 1'b0, 8'h05, 8'd1); char_out(8'h77);
    expect_quiet("R5 foreign address silent", 40);
    read_reg(4'd5, 8'h00, "R5 foreign write dropped");

    // R9: parity error on address byte
    set_rate(50);
    char_out(8'h79); char_out({7'h2A, 1'b0}, 1'b1); char_out(8'h05); char_out(8'd1);
    char_out(8'h77);
    expect_quiet("R9 parity error silent", 40);
    read_reg(4'd5, 8'h00, "R9 parity write dropped");

    // R9: stop-bit error on data byte
    set_rate(50);
    hdr(7'h2A, 1'b0, 8'h05, 8'd1); char_out(8'h77, 1'b0, 1'b1);
    expect_quiet("R9 stop error silent", 40);
    read_reg(4'd5, 8'h00, "R9 stop write dropped");

    // R9: count out of range
    set_rate(50);
    hdr(7'h2A, 1'b0, 8'h05, 8'd0);
    expect_quiet("R9 zero count silent", 40);
    set_rate(50);
    hdr(7'h2A, 1'b0, 8'h05, 8'd5);
    for (int i = 0; i < 5; i++) char_out(8'h40 + 8'(i));
    expect_quiet("R9 oversize count silent", 40);
    read_reg(4'd5, 8'h00, "R9 count write dropped");

    // R4: short gap inside a packet continues it
    set_rate(50);
    char_out(8'h79); idle_bits(8);
    char_out({7'h2A, 1'b0}); char_out(8'h06); char_out(8'd1); char_out(8'h5C);
    expect_byte(8'hC3, "R4 short gap ack");
    await_resp("R4");
    read_reg(4'd6, 8'h5C, "R4 short gap write");

    // R4: long gap after a partial packet starts a new one
    set_rate(50);
    char_out(8'h79); char_out({7'h2A, 1'b0});
    idle_bits(20);
    hdr(7'h2A, 1'b0, 8'h07, 8'd1); char_out(8'h3E);
    expect_byte(8'hC3, "R4 boundary ack");
    await_resp("R4");
    read_reg(4'd7, 8'h3E, "R4 boundary write");
    read_reg(4'd9, 8'h00, "R4 no stray write");

    summary();
    $finish;
  end
endmodule